// File: doc/BRIEF.md
# Receive Tap Delay Tuning Engine

This block picks the receive sampling point for a high-speed card interface. It works on a delay line whose input tap is chosen by a 5-bit select. After a start pulse it enables the input tap delay. It then steps the select through every setting in ascending order. At each setting it asks an external tuning-command agent whether a trial transfer passed.

Every change to the tap select happens inside a change-window strobe. The delay line may only take a new value while that strobe is high. During the sweep the engine counts failing taps and notes the last tap at which a fail turned into a pass. From these two values it computes the middle of the passing window, treating the tap range as a ring. It writes that tap with the same strobed sequence, then reports it, together with flags for the all-pass and all-fail cases.

Top module: `rx_tap_tuner`

## Requirements
- R1: After start, the engine sets the tap select to 0, 1, 2, ... 31 in that order and issues exactly one probe request per tap. Each probe request is issued only once the write of that tap has finished and the change window is low.
- R2: The tap-enable output is 0 after reset. It goes to 1 in the cycle after a start is accepted, is 1 before the first probe request, and stays 1 after tuning ends.
- R3: Each tap write runs in three steps. The change window rises with the select unchanged. In the next cycle the select takes its new value while the window stays high. In the cycle after that, the window falls. The select never changes at any other time.
- R4: The previous-result state is reset to "pass" at every start. A passing tap that follows a failing tap sets the window start to that tap, and a later such transition overwrites it. If no such transition occurs, the window start is 0.
- R5: Every failing tap adds one to the fail count. The count is cleared at start and can reach 32.
- R6: The final tap is (window start + ((32 - fail count) >> 1)) mod 32. It is written to the select with the R3 sequence and also presented on the result output.
- R7: If all 32 taps pass, the final tap is 16 and the all-pass flag is 1.
- R8: If all 32 taps fail, the all-fail flag is 1 and the computed tap (0) is still written to the select.
- R9: The pass input is used only in a cycle where the agent's done input is 1. Its value in any other cycle has no effect.
- R10: Busy is 1 from the cycle after start until the final write completes. Done is a one-cycle pulse in the first cycle where busy is 0 again. The flags and the result are valid from that pulse on.
- R11: A start pulse while busy is ignored. The sweep still issues 32 probes and produces one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a tuning run when the engine is idle |
| busy_o | output | 1 | A tuning run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| all_pass_o | output | 1 | The last run saw no failing tap |
| all_fail_o | output | 1 | The last run saw no passing tap |
| result_tap_o | output | 5 | Tap chosen by the last run |
| tap_en_o | output | 1 | Input tap delay enable |
| tap_sel_o | output | 5 | Input tap delay select to the delay line |
| chg_win_o | output | 1 | Change-window strobe around each select update |
| probe_req_o | output | 1 | One-cycle request to the tuning agent |
| probe_done_i | input | 1 | Agent's result is valid this cycle |
| probe_pass_i | input | 1 | Agent's result: 1 for pass, 0 for fail |

## Verification
The assertions take for granted that the tuning agent raises its done input only while a request is outstanding, and then for one cycle only. They also take for granted that start is used as a pulse. The bench agent holds to this: it answers each request with one done cycle after a chosen delay. Between answers it drives the pass input with the inverse of the true result, so the value is wrong whenever done is low. Stimulus also covers a second start pulse during a sweep, pass patterns whose window wraps past tap 31, and patterns with several passing windows.

// File: rtl/rx_tap_tuner_pkg.sv
package rx_tap_tuner_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SWEEP_WR,
    ST_SWEEP_WAIT,
    ST_PROBE,
    ST_CALC,
    ST_FINAL_WAIT
  } tuner_state_t;

  typedef enum logic [1:0] {
    WR_IDLE,
    WR_LOAD,
    WR_DROP
  } writer_state_t;

endpackage

// File: rtl/rx_tap_writer.sv
module rx_tap_writer
  import rx_tap_tuner_pkg::*;
#(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_req,
  input  logic [TAP_W-1:0] wr_val,
  output logic             chg_win,
  output logic [TAP_W-1:0] tap_sel,
  output logic             wr_done
);

  writer_state_t    st;
  logic [TAP_W-1:0] held_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= WR_IDLE;
      chg_win  <= 1'b0;
      tap_sel  <= '0;
      held_val <= '0;
      wr_done  <= 1'b0;
    end else begin
      wr_done <= 1'b0;
      case (st)
        WR_IDLE: if (wr_req) begin
          chg_win  <= 1'b1;
          held_val <= wr_val;
          st       <= WR_LOAD;
        end
        WR_LOAD: begin
          tap_sel <= held_val;
          st      <= WR_DROP;
        end
        WR_DROP: begin
          chg_win <= 1'b0;
          wr_done <= 1'b1;
          st      <= WR_IDLE;
        end
        default: st <= WR_IDLE;
      endcase
    end
  end

  // R3: select moves only inside a window that was already open
  p_sel_inside_window_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(tap_sel) |-> (chg_win && $past(chg_win)));

  // R3: window stays open at least two cycles
  p_window_width_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(chg_win) |=> chg_win);

endmodule

// File: rtl/rx_tap_window.sv
module rx_tap_window #(
  parameter int TAP_W = 5,
  parameter int CNT_W = TAP_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             sample,
  input  logic             pass,
  input  logic [TAP_W-1:0] tap_idx,
  output logic [CNT_W-1:0] fail_cnt,
  output logic [TAP_W-1:0] win_start
);

  localparam int NTAPS = 1 << TAP_W;

  logic prev_pass;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      prev_pass <= 1'b1;
      fail_cnt  <= '0;
      win_start <= '0;
    end else if (sample) begin
      if (pass && !prev_pass) win_start <= tap_idx;
      if (!pass) fail_cnt <= fail_cnt + 1'b1;
      prev_pass <= pass;
    end
  end

  // R5: fail count never exceeds the number of taps
  p_fail_bound_r5: assert property (@(posedge clk) disable iff (rst)
    fail_cnt <= CNT_W'(NTAPS));

  // R5: count moves only on a sampled fail
  p_fail_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!clear && !(sample && !pass)) |=> $stable(fail_cnt));

endmodule

// File: rtl/rx_tap_tuner.sv
module rx_tap_tuner
  import rx_tap_tuner_pkg::*;
#(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             all_pass_o,
  output logic             all_fail_o,
  output logic [TAP_W-1:0] result_tap_o,
  output logic             tap_en_o,
  output logic [TAP_W-1:0] tap_sel_o,
  output logic             chg_win_o,
  output logic             probe_req_o,
  input  logic             probe_done_i,
  input  logic             probe_pass_i
);

  localparam int NTAPS = 1 << TAP_W;
  localparam int CNT_W = TAP_W + 1;
  localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NTAPS - 1);

  tuner_state_t     st;
  logic [TAP_W-1:0] idx;
  logic             clr;
  logic             wr_req;
  logic [TAP_W-1:0] wr_val;
  logic             wr_done;
  logic             sample;
  logic [CNT_W-1:0] fail_cnt;
  logic [TAP_W-1:0] win_start;
  logic [CNT_W-1:0] pass_len;
  logic [TAP_W-1:0] center;

  assign sample   = (st == ST_PROBE) && probe_done_i;
  assign pass_len = CNT_W'(NTAPS) - fail_cnt;
  assign center   = win_start + TAP_W'(pass_len >> 1);

  rx_tap_writer #(.TAP_W(TAP_W)) u_writer (
    .clk     (clk),
    .rst     (rst),
    .wr_req  (wr_req),
    .wr_val  (wr_val),
    .chg_win (chg_win_o),
    .tap_sel (tap_sel_o),
    .wr_done (wr_done)
  );

  rx_tap_window #(.TAP_W(TAP_W), .CNT_W(CNT_W)) u_window (
    .clk       (clk),
    .rst       (rst),
    .clear     (clr),
    .sample    (sample),
    .pass      (probe_pass_i),
    .tap_idx   (idx),
    .fail_cnt  (fail_cnt),
    .win_start (win_start)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      idx          <= '0;
      clr          <= 1'b0;
      wr_req       <= 1'b0;
      wr_val       <= '0;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
      all_pass_o   <= 1'b0;
      all_fail_o   <= 1'b0;
      result_tap_o <= '0;
      tap_en_o     <= 1'b0;
      probe_req_o  <= 1'b0;
    end else begin
      done_o      <= 1'b0;
      wr_req      <= 1'b0;
      probe_req_o <= 1'b0;
      clr         <= 1'b0;
      case (st)
        ST_IDLE: if (start_i) begin
          busy_o     <= 1'b1;
          tap_en_o   <= 1'b1;
          idx        <= '0;
          clr        <= 1'b1;
          all_pass_o <= 1'b0;
          all_fail_o <= 1'b0;
          st         <= ST_SWEEP_WR;
        end
        ST_SWEEP_WR: begin
          wr_req <= 1'b1;
          wr_val <= idx;
          st     <= ST_SWEEP_WAIT;
        end
        ST_SWEEP_WAIT: if (wr_done) begin
          probe_req_o <= 1'b1;
          st          <= ST_PROBE;
        end
        ST_PROBE: if (probe_done_i) begin
          if (idx == LAST_TAP) begin
            st <= ST_CALC;
          end else begin
            idx <= idx + 1'b1;
            st  <= ST_SWEEP_WR;
          end
        end
        ST_CALC: begin
          wr_req       <= 1'b1;
          wr_val       <= center;
          result_tap_o <= center;
          all_pass_o   <= (fail_cnt == '0);
          all_fail_o   <= (fail_cnt == CNT_W'(NTAPS));
          st           <= ST_FINAL_WAIT;
        end
        ST_FINAL_WAIT: if (wr_done) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R10: done marks the cycle busy has just dropped
  p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  // R2: delay enable is on whenever the agent is asked
  p_en_before_probe_r2: assert property (@(posedge clk) disable iff (rst)
    probe_req_o |-> tap_en_o);

  // R1: probes never overlap a tap write
  p_probe_window_closed_r1: assert property (@(posedge clk) disable iff (rst)
    probe_req_o |-> !chg_win_o);

  // R7 / R8: the two outcome flags exclude each other
  p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !(all_pass_o && all_fail_o));

  // R11: a run in progress keeps going despite a new start
  p_busy_holds_r11: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o && st != ST_FINAL_WAIT) |=> busy_o);

endmodule

// File: tb/rx_tap_tuner_test.sv
module rx_tap_tuner_test;

  localparam int TAP_W = 5;
  localparam int NTAPS = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic probe_done_i = 1'b0;
  logic probe_pass_i = 1'b0;
  logic busy_o, done_o, all_pass_o, all_fail_o, tap_en_o, chg_win_o, probe_req_o;
  logic [TAP_W-1:0] result_tap_o, tap_sel_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [NTAPS-1:0] pattern = '0;
  int agent_delay = 1;
  int probe_count = 0;
  int order_errs = 0;
  int exp_tap = 0;
  int win_errs = 0;
  int window_closes = 0;
  int done_count = 0;

  always #4 clk = ~clk;

  rx_tap_tuner #(.TAP_W(TAP_W)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .all_pass_o(all_pass_o), .all_fail_o(all_fail_o), .result_tap_o(result_tap_o),
    .tap_en_o(tap_en_o), .tap_sel_o(tap_sel_o), .chg_win_o(chg_win_o),
    .probe_req_o(probe_req_o), .probe_done_i(probe_done_i), .probe_pass_i(probe_pass_i)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // tuning agent: answers each request; pass input is wrong whenever done is low
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (probe_req_o) begin
        int t;
        t = int'(tap_sel_o);
        probe_count++;
        if (t != exp_tap || !tap_en_o || chg_win_o) order_errs++;
        exp_tap++;
        probe_pass_i = ~pattern[t];
        repeat (agent_delay) @(negedge clk);
        probe_pass_i = pattern[t];
        probe_done_i = 1'b1;
        @(negedge clk);
        probe_done_i = 1'b0;
        probe_pass_i = ~pattern[t];
      end
    end
  end

  // write-sequence monitor
  initial begin
    logic prev_chg;
    logic [TAP_W-1:0] prev_sel;
    prev_chg = 1'b0;
    prev_sel = '0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (tap_sel_o != prev_sel && !(chg_win_o && prev_chg)) win_errs++;
        if (prev_chg && !chg_win_o) window_closes++;
        if (done_o) done_count++;
      end
      prev_chg = chg_win_o;
      prev_sel = tap_sel_o;
    end
  end

  // watchdog
  initial begin
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic int model(input logic [NTAPS-1:0] pat, output int fc);
    int ws;
    bit prev;
    ws = 0; fc = 0; prev = 1'b1;
    for (int t = 0; t < NTAPS; t++) begin
      if (pat[t] && !prev) ws = t;
      if (!pat[t]) fc++;
      prev = pat[t];
    end
    return (ws + ((NTAPS - fc) >> 1)) % NTAPS;
  endfunction

  task automatic run_case(input string name, input logic [NTAPS-1:0] pat,
                          input int dly, input bit restart);
    int fc, expv, guard;
    expv = model(pat, fc);
    pattern = pat;
    agent_delay = dly;
    probe_count = 0;
    order_errs = 0;
    exp_tap = 0;
    win_errs = 0;
    window_closes = 0;
    done_count = 0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, {name, " R10 busy after start"}, busy_o, 1);
    check(tap_en_o == 1'b1, {name, " R2 enable after start"}, tap_en_o, 1);
    if (restart) begin
      repeat (60) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    guard = 0;
    while (!done_o && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    check(done_o == 1'b1, {name, " R10 done pulse"}, done_o, 1);
    check(busy_o == 1'b0, {name, " R10 busy low at done"}, busy_o, 0);
    check(int'(result_tap_o) == expv, {name, " R6 result tap"}, result_tap_o, expv);
    check(int'(tap_sel_o) == expv, {name, " R6 select holds final tap"}, tap_sel_o, expv);
    check(all_pass_o == (fc == 0), {name, " R7 all-pass flag"}, all_pass_o, fc == 0);
    check(all_fail_o == (fc == NTAPS), {name, " R8 all-fail flag"}, all_fail_o, fc == NTAPS);
    repeat (20) @(negedge clk);
    check(probe_count == NTAPS, {name, " R1 R11 probe count"}, probe_count, NTAPS);
    check(order_errs == 0, {name, " R1 R2 tap order"}, order_errs, 0);
    check(win_errs == 0, {name, " R3 select only in window"}, win_errs, 0);
    check(window_closes == NTAPS + 1, {name, " R3 write count"}, window_closes, NTAPS + 1);
    check(done_count == 1, {name, " R11 single done"}, done_count, 1);
    check(tap_en_o == 1'b1, {name, " R2 enable stays on"}, tap_en_o, 1);
  endtask

  task automatic test_reset();
    check(busy_o == 1'b0, "R10 reset busy", busy_o, 0);
    check(tap_en_o == 1'b0, "R2 reset enable", tap_en_o, 0);
    check(chg_win_o == 1'b0, "R3 reset window", chg_win_o, 0);
    check(tap_sel_o == '0, "R3 reset select", tap_sel_o, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    // R4 R5 R6: fails 0..9, window from 10 -> tap 21
    run_case("mid_window", 32'hFFFF_FC00, 1, 1'b0);
    // R4 R6: window 28..3 wraps -> tap 0
    run_case("wrap_window", 32'hF000_000F, 3, 1'b0);
    // R7: no failing tap -> 16
    run_case("all_pass", 32'hFFFF_FFFF, 2, 1'b0);
    // R8: no passing tap -> 0, flag set
    run_case("all_fail", 32'h0000_0000, 1, 1'b0);
    // R4: two windows, last transition at 10 wins -> tap 23
    run_case("two_windows", 32'hFFFF_FCF0, 1, 1'b0);
    // R11: second start during sweep is ignored; R9 slow agent
    run_case("restart_busy", 32'h00FF_FF00, 5, 1'b1);
    // R9: single pass tap between fails
    run_case("single_pass", 32'h0001_0000, 4, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule